// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Sequencer

This block is the bus interface of a small processor core. The core presents one transfer at a time. Each transfer is a read or a write, to memory or to I/O space, with a 20-bit address, a byte-high enable, a write word, a segment code and the current interrupt-enable flag. The block turns that transfer into a bus cycle built from T-states on external pins. The low 16 address bits and the data word share one set of lines and take turns on them. The upper four address lines carry status once the address phase is over.

An address-latch strobe marks the address phase. A direction pin and a transceiver enable steer the external buffers. Read and write strobes time the data phase. A READY input, sampled at fixed points, stretches a cycle for slow targets. On a read, the data word is returned to the core together with a one-cycle completion pulse. The shared lines appear as an output word, an output enable and an input word, so that the tri-state pad sits outside the block.

Top module: `mbus_biu`

## Requirements
- R1: While reset is active and while idle, ale=0, rd_n=wr_n=den_n=1, ad_oe=0, m_io=1, dt_r_n=1, bhe_n=1, a_hi=0, rsp_done=0 and req_ready=1. After reset rsp_rdata=0.
- R2: A request is taken on a clock edge where req_ready=1 and req_valid=1. If READY is high when sampled, the cycle then runs exactly four states T1, T2, T3, T4. rsp_done is high only in T4, and the block is idle in the following cycle.
- R3: ALE is high for exactly the one cycle T1. In that cycle ad_oe=1, ad_out holds address bits [15:0], a_hi holds address bits [19:16] and bhe_n equals the requested byte-high enable. bhe_n is 1 in every other state.
- R4: m_io equals the requested space (1 = memory, 0 = I/O) from T1 through T4 and does not change within the cycle.
- R5: dt_r_n is 0 from T1 through T4 for a read and 1 for a write.
- R6: In a read, rd_n and den_n are 0 in T2, in every Tw and in T3. ad_oe is 0 from T2 through T4, and wr_n stays 1.
- R7: In a write, wr_n and den_n are 0 in T2, in every Tw and in T3. From T2 through T4, ad_oe=1 and ad_out holds the write word, and rd_n stays 1.
- R8: READY is sampled only at the end of T2 and at the end of each Tw. Each low sample inserts one Tw, which adds exactly one clock before T3. At any other time the value of READY has no effect.
- R9: From T2 through T4, a_hi[1:0] carries the segment code (00 extra, 01 stack, 10 code, 11 data), a_hi[2] carries the interrupt-enable flag captured when the request was taken, and a_hi[3]=0.
- R10: For a read, rsp_rdata takes the ad_in value present at the clock edge that ends T3. This value is shown during T4 and held until the next read completes. Writes leave rsp_rdata unchanged.
- R11: req_ready is 0 from T1 through T4. A req_valid raised while the block is busy is ignored: no new cycle starts from it, and the running cycle keeps its own address, data and status.
- R12: rd_n, wr_n and den_n are all 1 in T4, and rd_n and wr_n are never 0 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one period is one T-state |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Core requests a transfer |
| req_write | input | 1 | 1 = write, 0 = read |
| req_mem | input | 1 | 1 = memory space, 0 = I/O space |
| req_addr | input | 20 | Transfer address |
| req_bhe_n | input | 1 | Active-low byte-high enable |
| req_wdata | input | 16 | Write word |
| req_seg | input | 2 | Segment code for the status lines |
| ie_flag | input | 1 | Interrupt-enable flag for the status lines |
| req_ready | output | 1 | Block is idle and takes a request |
| rsp_done | output | 1 | One-cycle completion pulse in T4 |
| rsp_rdata | output | 16 | Captured read word |
| ad_out | output | 16 | Value driven on the shared address/data lines |
| ad_oe | output | 1 | Output enable for the shared lines |
| ad_in | input | 16 | Value seen on the shared lines |
| a_hi | output | 4 | Upper address in T1, status afterwards |
| bhe_n | output | 1 | Byte-high enable, driven in T1 |
| ale | output | 1 | Address-latch strobe |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| m_io | output | 1 | Memory (1) or I/O (0) access |
| dt_r_n | output | 1 | Transceiver direction: 1 transmit, 0 receive |
| den_n | output | 1 | Active-low transceiver enable |
| ready | input | 1 | Target ready; low inserts wait states |

## Verification
The hardest case to reach from the ports is a READY value that changes in the exact cycles where it is sampled. A chain of wait states must end on the right edge, and READY toggling outside the sampling points must be shown to have no effect. The bench drives READY low at the end of T2 and each Tw for a per-transfer wait count, and toggles it freely in every other state. A second hard case is a request raised while a cycle is running. The bench holds req_valid high with a different address, data and status from T1 to T4, then checks that the running cycle is unchanged and that no cycle follows.

// File: rtl/mbus_pkg.sv
package mbus_pkg;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_T1   = 3'd1,
    PH_T2   = 3'd2,
    PH_T3   = 3'd3,
    PH_T4   = 3'd4,
    PH_TW   = 3'd5
  } phase_e;

  localparam logic [1:0] SEG_EXTRA = 2'b00;
  localparam logic [1:0] SEG_STACK = 2'b01;
  localparam logic [1:0] SEG_CODE  = 2'b10;
  localparam logic [1:0] SEG_DATA  = 2'b11;

endpackage

// File: rtl/mbus_tseq.sv
module mbus_tseq
  import mbus_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  input  logic   ready,
  output phase_e phase
);

  phase_e phase_nx;

  always_comb begin
    phase_nx = phase;
    unique case (phase)
      PH_IDLE: if (start) phase_nx = PH_T1;
      PH_T1:   phase_nx = PH_T2;
      PH_T2:   phase_nx = ready ? PH_T3 : PH_TW;
      PH_TW:   phase_nx = ready ? PH_T3 : PH_TW;
      PH_T3:   phase_nx = PH_T4;
      PH_T4:   phase_nx = PH_IDLE;
      default: phase_nx = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= PH_IDLE;
    else        phase <= phase_nx;
  end

endmodule

// File: rtl/mbus_reqreg.sv
module mbus_reqreg #(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  parameter int SEG_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic              cap_en,
  input  logic              in_write,
  input  logic              in_mem,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic              in_bhe_n,
  input  logic [DATA_W-1:0] in_wdata,
  input  logic [SEG_W-1:0]  in_seg,
  input  logic              in_ie,
  input  logic [DATA_W-1:0] bus_in,
  output logic              q_write,
  output logic              q_mem,
  output logic [ADDR_W-1:0] q_addr,
  output logic              q_bhe_n,
  output logic [DATA_W-1:0] q_wdata,
  output logic [SEG_W-1:0]  q_seg,
  output logic              q_ie,
  output logic [DATA_W-1:0] q_rdata
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_write <= 1'b0;
      q_mem   <= 1'b1;
      q_addr  <= '0;
      q_bhe_n <= 1'b1;
      q_wdata <= '0;
      q_seg   <= '0;
      q_ie    <= 1'b0;
    end else if (load_en) begin
      q_write <= in_write;
      q_mem   <= in_mem;
      q_addr  <= in_addr;
      q_bhe_n <= in_bhe_n;
      q_wdata <= in_wdata;
      q_seg   <= in_seg;
      q_ie    <= in_ie;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q_rdata <= '0;
    else if (cap_en) q_rdata <= bus_in;
  end

endmodule

// File: rtl/mbus_pinmux.sv
module mbus_pinmux
  import mbus_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  parameter int SEG_W  = 2,
  localparam int HI_W  = ADDR_W - DATA_W
) (
  input  phase_e            phase,
  input  logic              q_write,
  input  logic              q_mem,
  input  logic [ADDR_W-1:0] q_addr,
  input  logic              q_bhe_n,
  input  logic [DATA_W-1:0] q_wdata,
  input  logic [SEG_W-1:0]  q_seg,
  input  logic              q_ie,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe,
  output logic [HI_W-1:0]   a_hi,
  output logic              bhe_n,
  output logic              ale,
  output logic              rd_n,
  output logic              wr_n,
  output logic              m_io,
  output logic              dt_r_n,
  output logic              den_n
);

  logic            in_t1;
  logic            in_data;
  logic            busy;
  logic            post_addr;
  logic [HI_W-1:0] status;

  assign in_t1     = (phase == PH_T1);
  assign in_data   = (phase == PH_T2) || (phase == PH_TW) || (phase == PH_T3);
  assign busy      = (phase != PH_IDLE);
  assign post_addr = busy && !in_t1;

  generate
    if (HI_W >= SEG_W + 2) begin : g_full_status
      always_comb begin
        status              = '0;
        status[SEG_W-1:0]   = q_seg;
        status[SEG_W]       = q_ie;
        status[SEG_W+1]     = 1'b0;
      end
    end else if (HI_W > SEG_W) begin : g_seg_ie_status
      always_comb begin
        status            = '0;
        status[SEG_W-1:0] = q_seg;
        status[SEG_W]     = q_ie;
      end
    end else begin : g_seg_status
      always_comb status = q_seg[HI_W-1:0];
    end
  endgenerate

  always_comb begin
    ale    = in_t1;
    bhe_n  = in_t1 ? q_bhe_n : 1'b1;
    m_io   = busy ? q_mem : 1'b1;
    dt_r_n = busy ? q_write : 1'b1;
    den_n  = !in_data;
    rd_n   = !(in_data && !q_write);
    wr_n   = !(in_data && q_write);
    if (in_t1)          a_hi = q_addr[ADDR_W-1:DATA_W];
    else if (post_addr) a_hi = status;
    else                a_hi = '0;
    if (in_t1) begin
      ad_oe  = 1'b1;
      ad_out = q_addr[DATA_W-1:0];
    end else if (post_addr && q_write) begin
      ad_oe  = 1'b1;
      ad_out = q_wdata;
    end else begin
      ad_oe  = 1'b0;
      ad_out = '0;
    end
  end

endmodule

// File: rtl/mbus_biu.sv
module mbus_biu
  import mbus_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  parameter int SEG_W  = 2,
  localparam int HI_W  = ADDR_W - DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_mem,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_bhe_n,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [SEG_W-1:0]  req_seg,
  input  logic              ie_flag,
  output logic              req_ready,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe,
  input  logic [DATA_W-1:0] ad_in,
  output logic [HI_W-1:0]   a_hi,
  output logic              bhe_n,
  output logic              ale,
  output logic              rd_n,
  output logic              wr_n,
  output logic              m_io,
  output logic              dt_r_n,
  output logic              den_n,
  input  logic              ready
);

  logic [1:0]        rst_pipe;
  logic              rst_q_n;
  phase_e            phase;
  logic              load_en;
  logic              cap_en;
  logic              q_write;
  logic              q_mem;
  logic [ADDR_W-1:0] q_addr;
  logic              q_bhe_n;
  logic [DATA_W-1:0] q_wdata;
  logic [SEG_W-1:0]  q_seg;
  logic              q_ie;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q_n = rst_pipe[1];

  assign req_ready = (phase == PH_IDLE);
  assign rsp_done  = (phase == PH_T4);
  assign load_en   = req_ready && req_valid;
  assign cap_en    = (phase == PH_T3) && !q_write;

  mbus_tseq u_tseq (
    .clk   (clk),
    .rst_n (rst_q_n),
    .start (req_valid),
    .ready (ready),
    .phase (phase)
  );

  mbus_reqreg #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .SEG_W  (SEG_W)
  ) u_reqreg (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .load_en  (load_en),
    .cap_en   (cap_en),
    .in_write (req_write),
    .in_mem   (req_mem),
    .in_addr  (req_addr),
    .in_bhe_n (req_bhe_n),
    .in_wdata (req_wdata),
    .in_seg   (req_seg),
    .in_ie    (ie_flag),
    .bus_in   (ad_in),
    .q_write  (q_write),
    .q_mem    (q_mem),
    .q_addr   (q_addr),
    .q_bhe_n  (q_bhe_n),
    .q_wdata  (q_wdata),
    .q_seg    (q_seg),
    .q_ie     (q_ie),
    .q_rdata  (rsp_rdata)
  );

  mbus_pinmux #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .SEG_W  (SEG_W)
  ) u_pinmux (
    .phase   (phase),
    .q_write (q_write),
    .q_mem   (q_mem),
    .q_addr  (q_addr),
    .q_bhe_n (q_bhe_n),
    .q_wdata (q_wdata),
    .q_seg   (q_seg),
    .q_ie    (q_ie),
    .ad_out  (ad_out),
    .ad_oe   (ad_oe),
    .a_hi    (a_hi),
    .bhe_n   (bhe_n),
    .ale     (ale),
    .rd_n    (rd_n),
    .wr_n    (wr_n),
    .m_io    (m_io),
    .dt_r_n  (dt_r_n),
    .den_n   (den_n)
  );

endmodule

// File: rtl/mbus_biu_chk.sv
module mbus_biu_chk (
  input logic clk,
  input logic rst_q_n,
  input logic req_ready,
  input logic rsp_done,
  input logic ad_oe,
  input logic ale,
  input logic rd_n,
  input logic wr_n,
  input logic m_io,
  input logic dt_r_n,
  input logic den_n
);

  assert_ale_addr_phase_R3: assert property (@(posedge clk) disable iff (!rst_q_n)
    ale |-> (ad_oe && rd_n && wr_n && den_n));

  assert_ale_single_R3: assert property (@(posedge clk) disable iff (!rst_q_n)
    ale |=> !ale);

  assert_mio_stable_R4: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!req_ready && !ale) |-> $stable(m_io));

  assert_dir_stable_R5: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!req_ready && !ale) |-> $stable(dt_r_n));

  assert_read_released_R6: assert property (@(posedge clk) disable iff (!rst_q_n)
    !rd_n |-> (!ad_oe && !dt_r_n && !den_n));

  assert_write_driven_R7: assert property (@(posedge clk) disable iff (!rst_q_n)
    !wr_n |-> (ad_oe && dt_r_n && !den_n));

  assert_done_then_idle_R2: assert property (@(posedge clk) disable iff (!rst_q_n)
    rsp_done |=> (req_ready && !rsp_done));

  assert_start_from_idle_R11: assert property (@(posedge clk) disable iff (!rst_q_n)
    ale |-> $past(req_ready));

  assert_strobes_off_t4_R12: assert property (@(posedge clk) disable iff (!rst_q_n)
    rsp_done |-> (rd_n && wr_n && den_n));

  assert_no_rd_wr_overlap_R12: assert property (@(posedge clk) disable iff (!rst_q_n)
    1'b1 |-> (rd_n || wr_n));

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_q_n)
    req_ready |-> (!ale && rd_n && wr_n && den_n && !ad_oe && !rsp_done));

endmodule

bind mbus_biu mbus_biu_chk u_chk (
  .clk       (clk),
  .rst_q_n   (rst_q_n),
  .req_ready (req_ready),
  .rsp_done  (rsp_done),
  .ad_oe     (ad_oe),
  .ale       (ale),
  .rd_n      (rd_n),
  .wr_n      (wr_n),
  .m_io      (m_io),
  .dt_r_n    (dt_r_n),
  .den_n     (den_n)
);

// File: tb/tb_mbus_biu.sv
`timescale 1ns/1ps
module tb_mbus_biu;

  logic        clk;
  logic        rst_n;
  logic        req_valid, req_write, req_mem, req_bhe_n, ie_flag, ready;
  logic [19:0] req_addr;
  logic [15:0] req_wdata, ad_in;
  logic [1:0]  req_seg;
  logic        req_ready, rsp_done, ad_oe, bhe_n, ale, rd_n, wr_n, m_io, dt_r_n, den_n;
  logic [15:0] rsp_rdata, ad_out;
  logic [3:0]  a_hi;

  mbus_biu dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_mem(req_mem), .req_addr(req_addr), .req_bhe_n(req_bhe_n),
    .req_wdata(req_wdata), .req_seg(req_seg), .ie_flag(ie_flag),
    .req_ready(req_ready), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
    .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in), .a_hi(a_hi), .bhe_n(bhe_n),
    .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .m_io(m_io), .dt_r_n(dt_r_n),
    .den_n(den_n), .ready(ready)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int n_run = 0;
  int n_fail = 0;
  bit chk_en = 0;
  bit done_flag = 0;
  int cyc = 0;
  int wleft = 0;

  // Reference model state: 0 idle, 1..4 T1..T4, 5 wait state
  int          m_ph = 0;
  logic        m_wr, m_mem, m_bhe, m_ie;
  logic [19:0] m_addr;
  logic [15:0] m_wdata, m_rdata;
  logic [1:0]  m_seg;

  task automatic chk(input string req, input string nm, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s cycle %0d actual=%h expected=%h", req, nm, cyc, act, exp);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_rdata = '0; m_wr = 0; m_mem = 1; m_bhe = 1; m_ie = 0;
      m_addr = '0; m_wdata = '0; m_seg = '0;
    end else begin
      case (m_ph)
        0: if (req_valid) begin
             m_wr = req_write; m_mem = req_mem; m_addr = req_addr; m_bhe = req_bhe_n;
             m_wdata = req_wdata; m_seg = req_seg; m_ie = ie_flag; m_ph = 1;
           end
        1: m_ph = 2;
        2, 5: m_ph = ready ? 3 : 5;
        3: begin if (!m_wr) m_rdata = ad_in; m_ph = 4; end
        default: m_ph = 0;
      endcase
    end
  end

  // Compare every output against the model away from the active edge
  always @(negedge clk) begin
    bit datap;
    bit busy;
    cyc++;
    if (chk_en) begin
      datap = (m_ph == 2) || (m_ph == 5) || (m_ph == 3);
      busy  = (m_ph != 0);
      chk("R1_R11", "req_ready", req_ready, m_ph == 0);
      chk("R2", "rsp_done", rsp_done, m_ph == 4);
      chk("R10", "rsp_rdata", rsp_rdata, m_rdata);
      chk("R3", "ale", ale, m_ph == 1);
      chk("R3", "bhe_n", bhe_n, (m_ph == 1) ? m_bhe : 1'b1);
      chk("R4", "m_io", m_io, busy ? m_mem : 1'b1);
      chk("R5", "dt_r_n", dt_r_n, busy ? m_wr : 1'b1);
      chk("R6_R12", "rd_n", rd_n, !(datap && !m_wr));
      chk("R7_R12", "wr_n", wr_n, !(datap && m_wr));
      chk("R6_R7", "den_n", den_n, !datap);
      chk("R6_R7", "ad_oe", ad_oe, (m_ph == 1) || (busy && m_wr));
      if (m_ph == 1) chk("R3", "ad_out", ad_out, m_addr[15:0]);
      else if (busy && m_wr) chk("R7", "ad_out", ad_out, m_wdata);
      if (m_ph == 1) chk("R3", "a_hi", a_hi, m_addr[19:16]);
      else if (busy) chk("R9", "a_hi", a_hi, {1'b0, m_ie, m_seg});
      else chk("R1", "a_hi", a_hi, 4'h0);
    end
    // READY and bus data drive
    if (m_ph == 2 || m_ph == 5) begin
      ready = (wleft == 0);
      if (wleft > 0) wleft--;
    end else begin
      ready = cyc[0];   // R8: toggles freely where it is not sampled
    end
    ad_in = {ad_in[14:0], ad_in[15] ^ ad_in[13] ^ ad_in[12] ^ ad_in[10]};
  end

  always @(posedge clk) begin
    if (cyc > 100000 && !done_flag) begin
      done_flag = 1;
      n_fail++;
      $display("FAIL watchdog expired at cycle %0d actual=hung expected=finished", cyc);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic run_req(input bit w, input bit mem, input logic [19:0] addr, input bit bhe,
                         input logic [15:0] wd, input logic [1:0] seg, input bit ie,
                         input int nwait, input bit hold_busy);
    @(negedge clk);
    req_valid = 1; req_write = w; req_mem = mem; req_addr = addr; req_bhe_n = bhe;
    req_wdata = wd; req_seg = seg; ie_flag = ie; wleft = nwait;
    do @(negedge clk); while (m_ph == 0);
    if (hold_busy) begin
      // R11: conflicting request while busy must be ignored
      req_write = !w; req_mem = !mem; req_addr = ~addr; req_bhe_n = !bhe;
      req_wdata = ~wd; req_seg = ~seg; ie_flag = !ie;
    end else begin
      req_valid = 0;
    end
    do @(negedge clk); while (m_ph != 4);
    req_valid = 0;
    do @(negedge clk); while (m_ph != 0);
  endtask

  initial begin
    req_valid = 0; req_write = 0; req_mem = 1; req_addr = '0; req_bhe_n = 1;
    req_wdata = '0; req_seg = '0; ie_flag = 0; ready = 1; ad_in = 16'hACE1;
    rst_n = 0;
    #1 chk_en = 1;   // R1: outputs during reset
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R2/R3/R6/R9/R10: memory read, code segment, no wait
    run_req(0, 1, 20'hABCDE, 0, 16'h0000, 2'b10, 1, 0, 0);
    // R7/R9: memory write, data segment
    run_req(1, 1, 20'h12345, 1, 16'hBEEF, 2'b11, 0, 0, 0);
    // R4/R8: I/O read with one wait state
    run_req(0, 0, 20'h003F8, 1, 16'h0000, 2'b11, 0, 1, 0);
    // R8: I/O write with two wait states, stack segment
    run_req(1, 0, 20'h00060, 0, 16'h5A5A, 2'b01, 1, 2, 0);
    // R11: busy-time request ignored, extra segment, three waits
    run_req(0, 1, 20'hF0F0F, 0, 16'h0000, 2'b00, 1, 3, 1);
    run_req(1, 1, 20'h80001, 1, 16'h1234, 2'b01, 0, 0, 1);
    // R10: write between reads leaves read data held
    run_req(0, 1, 20'h7FFFF, 0, 16'h0000, 2'b10, 0, 5, 0);
    for (int i = 0; i < 12; i++)
      run_req(i[0], i[1], 20'h1000 * i + 20'h0033 * i, i[2], 16'h1111 * i,
              i[1:0], i[3], i % 4, i[2]);
    repeat (3) @(negedge clk);
    chk_en = 0;
    if (!done_flag) begin
      done_flag = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule